// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus. A 64-bit up-counter, held as two 32-bit halves, is compared against a 64-bit period. Software arms the watchdog by writing two fixed 16-bit key values, one after the other, into the key field of the watchdog control word. After arming, every timer setting is frozen and the watchdog cannot be switched off. Only a hardware reset returns it to the disabled state.

To keep the system alive while the watchdog runs, software repeats the two-key sequence. This restarts the counter from zero. If the count reaches the period first, the block sets a sticky timeout flag and raises a one-cycle reset request for the rest of the chip. Reads are combinational: `bus_rdata` shows the addressed register during any cycle in which `bus_rd` is high, and is zero otherwise.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the block is disabled. The counter halves, period halves, timer control and global control read 0. The watchdog control word reads 0. `wd_rst_req` is low. Offset 0x00 reads the `ID_VALUE` parameter.
- R2: Byte offsets: 0x08 counter low, 0x0C counter high, 0x10 period low, 0x14 period high, 0x18 timer control (mode in bits 7:6), 0x1C global control, 0x20 watchdog control. While disabled, a write to any of these is read back unchanged. In the watchdog control word the key field (bits 31:16) always reads 0.
- R3: Watchdog control bit 14 is the enable and bit 15 is the timeout flag. A write whose key is 0xA5C6 with bit 14 set moves the block from disabled to pre-active. A following write of key 0xDA7E makes it active. Bit 14 reads 1 in every armed state.
- R4: A key other than the one expected next leaves the state unchanged. This covers an unknown value, 0xDA7E while disabled, 0xA5C6 with bit 14 clear, and 0xDA7E while active.
- R5: In pre-active, active or service state, writes to the counter, period, timer control and global control registers are ignored.
- R6: The counter advances by 1 per clock, carrying from the low half into the high half. It advances only in active or service state and only when global control bits 1:0 are 3 and bits 3:2 are 2. In pre-active state it holds.
- R7: When a counting cycle has counter equal to period, the next edge clears the counter, sets the flag and drives `wd_rst_req` high for that cycle. Starting from count C0 and period P, the request appears P-C0+1 clocks after the arming edge.
- R8: In active state, key 0xA5C6 enters service state and then key 0xDA7E restarts the counter at 0 and returns to active.
- R9: No register write disables an armed watchdog. Writing 1 to bit 15 clears the flag only while disabled, so the same write has no effect once armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |
| wd_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench sweeps every start count up to every small period and measures the edge distance from arming to the reset request. An off-by-one in the compare or in the arming cycle shows up as a distance that is one too short or one too long. A start just below a 32-bit boundary exposes a missing carry into the high half, because the timeout would then never come on time. Out-of-order and unknown keys, a first key without the enable bit, and a second key while active are each followed by a counter or register read. A loose state machine would then show up as a restarted counter or as a register that is still writable. After arming, the bench tries to rewrite the period, clear the global control, drop the enable and clear the flag. A design that honours any of these writes would read back the new value or stop counting.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  localparam logic [KEY_W-1:0] KEY_ARM = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_FIN = 16'hDA7E;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h08;
  localparam logic [7:0] OFS_CNT_HI = 8'h0C;
  localparam logic [7:0] OFS_PER_LO = 8'h10;
  localparam logic [7:0] OFS_PER_HI = 8'h14;
  localparam logic [7:0] OFS_TCTL   = 8'h18;
  localparam logic [7:0] OFS_GCTL   = 8'h1C;
  localparam logic [7:0] OFS_WCTL   = 8'h20;

  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_RUN = 2'd2,
    WD_SVC = 2'd3
  } wd_state_e;

  // next state after one write of the key field
  function automatic wd_state_e wd_next(wd_state_e s, logic [KEY_W-1:0] key, logic en);
    wd_state_e n;
    n = s;
    case (s)
      WD_OFF: if (key == KEY_ARM && en) n = WD_PRE;
      WD_PRE: if (key == KEY_FIN)       n = WD_RUN;
      WD_RUN: if (key == KEY_ARM)       n = WD_SVC;
      WD_SVC: if (key == KEY_FIN)       n = WD_RUN;
      default: n = s;
    endcase
    return n;
  endfunction

  // counting needs a running state, both halves out of reset and watchdog mode
  function automatic logic wd_counting(wd_state_e s, logic [3:0] gctl);
    return (s == WD_RUN || s == WD_SVC) && (gctl[1:0] == 2'b11) && (gctl[3:2] == 2'd2);
  endfunction

endpackage

// File: rtl/wdog_keyfsm.sv
module wdog_keyfsm
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  output wd_state_e        state,
  output logic             restart
);

  wd_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WD_OFF;
    else if (key_wr) state_q <= wd_next(state_q, key, en_bit);
  end

  assign state   = state_q;
  assign restart = key_wr && (state_q == WD_SVC) && (key == KEY_FIN);

  // R9
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != WD_OFF) |=> (state_q != WD_OFF));

  // R8
  run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN) |=> (state_q == WD_RUN || state_q == WD_SVC));

  // R4
  no_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(state_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  input  logic [2*HALF_W-1:0] period,
  input  logic              cnt_en,
  input  logic              restart,
  output logic [2*HALF_W-1:0] count,
  output logic              to_hit
);

  localparam int CW = 2 * HALF_W;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;

  assign to_hit = cnt_en && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= to_hit ? '0 : cnt_q + ONE;
    end else begin
      if (ld_lo) cnt_q[HALF_W-1:0]  <= ld_data;
      if (ld_hi) cnt_q[CW-1:HALF_W] <= ld_data;
    end
  end

  assign count = cnt_q;

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !restart && !to_hit) |=> (cnt_q == $past(cnt_q) + ONE));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_hit && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              wd_rst_req
);

  localparam int HW = DATA_W;

  logic [HW-1:0]   per_lo_q, per_hi_q, tctl_q, gctl_q;
  logic            flag_q, req_q;
  wd_state_e       state;
  logic            restart, to_hit, locked, cnt_en;
  logic [2*HW-1:0] count;

  function automatic logic at(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_clo, wr_chi, wr_plo, wr_phi, wr_tc, wr_gc, wr_wc;
  assign wr_clo = bus_wr && at(bus_addr, OFS_CNT_LO);
  assign wr_chi = bus_wr && at(bus_addr, OFS_CNT_HI);
  assign wr_plo = bus_wr && at(bus_addr, OFS_PER_LO);
  assign wr_phi = bus_wr && at(bus_addr, OFS_PER_HI);
  assign wr_tc  = bus_wr && at(bus_addr, OFS_TCTL);
  assign wr_gc  = bus_wr && at(bus_addr, OFS_GCTL);
  assign wr_wc  = bus_wr && at(bus_addr, OFS_WCTL);

  assign locked = (state != WD_OFF);
  assign cnt_en = wd_counting(state, gctl_q[3:0]);

  wdog_keyfsm i_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wr_wc),
    .key     (bus_wdata[31:16]),
    .en_bit  (bus_wdata[14]),
    .state   (state),
    .restart (restart)
  );

  wdog_counter #(.HALF_W(HW)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (wr_clo && !locked),
    .ld_hi   (wr_chi && !locked),
    .ld_data (bus_wdata),
    .period  ({per_hi_q, per_lo_q}),
    .cnt_en  (cnt_en),
    .restart (restart),
    .count   (count),
    .to_hit  (to_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_lo_q <= '0;
      per_hi_q <= '0;
      tctl_q   <= '0;
      gctl_q   <= '0;
      flag_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (!locked) begin
        if (wr_plo) per_lo_q <= bus_wdata;
        if (wr_phi) per_hi_q <= bus_wdata;
        if (wr_tc)  tctl_q   <= bus_wdata;
        if (wr_gc)  gctl_q   <= bus_wdata;
        if (wr_wc && bus_wdata[15]) flag_q <= 1'b0;
      end
      if (to_hit) flag_q <= 1'b1;
      req_q <= to_hit;
    end
  end

  assign wd_rst_req = req_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if      (at(bus_addr, OFS_ID))     bus_rdata = ID_VALUE;
      else if (at(bus_addr, OFS_CNT_LO)) bus_rdata = count[HW-1:0];
      else if (at(bus_addr, OFS_CNT_HI)) bus_rdata = count[2*HW-1:HW];
      else if (at(bus_addr, OFS_PER_LO)) bus_rdata = per_lo_q;
      else if (at(bus_addr, OFS_PER_HI)) bus_rdata = per_hi_q;
      else if (at(bus_addr, OFS_TCTL))   bus_rdata = tctl_q;
      else if (at(bus_addr, OFS_GCTL))   bus_rdata = gctl_q;
      else if (at(bus_addr, OFS_WCTL))   bus_rdata = {16'h0000, flag_q, locked, 14'h0000};
      else                               bus_rdata = '0;
    end
  end

  // R5
  period_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(per_lo_q) && $stable(per_hi_q) && $stable(gctl_q) && $stable(tctl_q)));

  // R7
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> flag_q);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && locked) |=> flag_q);

  // R6
  no_count_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_PRE && !wr_wc) |=> $stable(count));

endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        wd_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] ID_EXP = 32'h5744_0001;
  localparam logic [31:0] W_ARM  = 32'hA5C6_4000;
  localparam logic [31:0] W_FIN  = 32'hDA7E_4000;
  localparam logic [31:0] GC_WD  = 32'h0000_000B;

  always #4 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wd_rst_req(wd_rst_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic cfg(input logic [63:0] c0, input logic [63:0] p, input logic [31:0] gc);
    wr(8'h08, c0[31:0]);
    wr(8'h0C, c0[63:32]);
    wr(8'h10, p[31:0]);
    wr(8'h14, p[63:32]);
    wr(8'h18, 32'h80);
    wr(8'h1C, gc);
  endtask

  task automatic arm();
    wr(8'h20, W_ARM);
    wr(8'h20, W_FIN);
  endtask

  task automatic edges_to_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wd_rst_req && n < 300);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, c;
    int n;

    // R1 reset state
    do_reset();
    check("R1 rst_req", {63'd0, wd_rst_req}, 64'd0);
    rd(8'h00, d); check("R1 id", {32'd0, d}, {32'd0, ID_EXP});
    for (int a = 8'h08; a <= 8'h20; a += 4) begin
      rd(8'(a), d); check("R1 zero", {32'd0, d}, 64'd0);
    end

    // R2 readback while disabled, key field reads zero
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); check("R2 per_lo", {32'd0, d}, 64'h1234_5678);
    wr(8'h14, 32'h0000_00AB); rd(8'h14, d); check("R2 per_hi", {32'd0, d}, 64'hAB);
    wr(8'h18, 32'h80);        rd(8'h18, d); check("R2 tctl", {32'd0, d}, 64'h80);
    wr(8'h1C, GC_WD);         rd(8'h1C, d); check("R2 gctl", {32'd0, d}, {32'd0, GC_WD});
    wr(8'h08, 32'h11);        rd(8'h08, d); check("R2 cnt_lo", {32'd0, d}, 64'h11);
    wr(8'h20, 32'h5555_0000); rd(8'h20, d); check("R2 key reads 0", {32'd0, d}, 64'd0);

    // R4 wrong keys while disabled
    wr(8'h20, 32'h1234_4000);
    wr(8'h20, W_FIN);
    wr(8'h20, 32'hA5C6_0000);
    wr(8'h20, W_FIN);
    rd(8'h20, d); check("R4 still disabled", {32'd0, d}, 64'd0);
    wr(8'h10, 32'h7); rd(8'h10, d); check("R4 still writable", {32'd0, d}, 64'h7);

    // R3/R5/R6 pre-active: armed bit, frozen, no counting
    do_reset();
    cfg(64'd3, 64'd50, GC_WD);
    wr(8'h20, W_ARM);
    rd(8'h20, d); check("R3 pre enable bit", {32'd0, d}, 64'h4000);
    repeat (5) @(negedge clk);
    rd(8'h08, d); check("R6 pre holds", {32'd0, d}, 64'd3);
    wr(8'h10, 32'h9); rd(8'h10, d); check("R5 pre period frozen", {32'd0, d}, 64'd50);
    wr(8'h20, W_FIN);
    rd(8'h08, d); check("R3 active start", {32'd0, d}, 64'd3);
    repeat (4) @(negedge clk);
    rd(8'h08, d); check("R6 counts", {32'd0, d}, 64'd7);

    // R5 writes frozen while active
    wr(8'h08, 32'h0); rd(8'h08, d); check("R5 cnt not loaded", {32'd0, d}, 64'd8);
    wr(8'h1C, 32'h0); rd(8'h1C, d); check("R5 gctl frozen", {32'd0, d}, {32'd0, GC_WD});
    rd(8'h08, d); check("R5 still counting", {32'd0, d}, 64'd9);

    // R4 second key while active: no restart
    rd(8'h08, c);
    wr(8'h20, W_FIN); rd(8'h08, d); check("R4 FIN in run", {32'd0, d}, {32'd0, c + 32'd1});
    wr(8'h20, 32'hBEEF_4000); rd(8'h08, d); check("R4 bad key run", {32'd0, d}, {32'd0, c + 32'd2});

    // R9 cannot disable
    wr(8'h20, 32'h0000_0000);
    rd(8'h20, d); check("R9 enable sticks", {32'd0, d}, 64'h4000);
    rd(8'h08, d); check("R9 keeps counting", {32'd0, d}, {32'd0, c + 32'd3});

    // R6 wrong global control: no counting
    do_reset();
    cfg(64'd2, 64'd40, 32'h3);
    arm();
    repeat (6) @(negedge clk);
    rd(8'h08, d); check("R6 mode off holds", {32'd0, d}, 64'd2);

    // R6/R7 carry across halves
    do_reset();
    cfg(64'h0000_0000_FFFF_FFFE, 64'h0000_0001_0000_0002, GC_WD);
    arm();
    repeat (3) @(negedge clk);
    rd(8'h08, d); check("R6 carry lo", {32'd0, d}, 64'd1);
    rd(8'h0C, d); check("R6 carry hi", {32'd0, d}, 64'd1);
    edges_to_req(n);
    check("R7 carry timeout", 64'(n), 64'd2);

    // R7 sweep of start count and period
    for (int p = 0; p < 8; p++) begin
      for (int c0 = 0; c0 <= p; c0++) begin
        do_reset();
        cfg(64'(c0), 64'(p), GC_WD);
        arm();
        if (p == c0) begin
          n = 0;
          @(negedge clk); n++;
        end else begin
          edges_to_req(n);
        end
        check("R7 edges to request", 64'(n), 64'(p - c0 + 1));
        check("R7 request high", {63'd0, wd_rst_req}, 64'd1);
        if (p > 0) begin
          @(negedge clk);
          check("R7 one cycle", {63'd0, wd_rst_req}, 64'd0);
        end
      end
    end

    // R8 service restarts; R9 flag not cleared while armed
    do_reset();
    cfg(64'd0, 64'd20, GC_WD);
    arm();
    repeat (10) @(negedge clk);
    wr(8'h20, W_ARM);
    wr(8'h20, W_FIN);
    rd(8'h08, d); check("R8 restart zero", {32'd0, d}, 64'd0);
    edges_to_req(n);
    check("R8 edges after service", 64'(n), 64'd21);
    rd(8'h20, d); check("R7 flag set", {32'd0, d}, 64'hC000);
    wr(8'h20, 32'h0000_8000);
    rd(8'h20, d); check("R9 flag kept", {32'd0, d}, 64'hC000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule